// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked working form and turns it into a 32-bit IEEE single word of sign, 8-bit biased exponent and 23-bit fraction. The working form has a 2-bit class, a sign, a signed 16-bit unbiased exponent and a 32-bit mantissa. For ordinary numbers the explicit leading one sits in the top bit, and every bit below the single-precision fraction acts as a guard or sticky bit. The block rounds in one of four modes and handles zero, infinity, NaN, subnormal and normal results. It raises overflow, underflow and inexact flags. An underflow-trap-enable input changes when underflow is reported.

One result is accepted on every cycle that `in_valid` is high. The packed word and its flags appear on the registered outputs one clock later. Mantissa width, fraction width, exponent width and input exponent width are parameters, and the bias and the all-ones exponent are derived from them.

Top module: `sp_packer`

## Requirements
- R1: Class code 00 (zero) packs as the sign followed by 31 zero bits. Class code 10 (infinity) packs as the sign, exponent 0xFF and a zero fraction. Neither raises a flag, and both ignore the mantissa and the exponent.
- R2: Class code 11 (NaN) packs as the sign, exponent 0xFF and a fraction equal to mantissa bits [30:8]. No flag is raised.
- R3: Reset clears `out_valid`, `out_word` and all flags. `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `out_word` and the flags keep their values.
- R4: For class code 01 (number) the biased exponent is the input exponent plus 127. If it is 1 or more, the fraction comes from mantissa bits [30:8], the round bit is bit 7 and the sticky bit is the OR of bits [6:0]. Rounding modes: 0 = nearest, ties to even; 1 = toward zero; 2 = toward plus infinity; 3 = toward minus infinity. Inexact is set whenever the round bit or the sticky bit is set.
- R5: If a normal value rounds up from an all-ones fraction, the exponent rises by one and the fraction becomes zero.
- R6: If the biased exponent is 0 or below, the mantissa is shifted right by a further (1 - biased exponent) places before rounding and the exponent field is 0. Underflow is raised when the result is inexact or when `uf_trap_en` is high.
- R7: A subnormal value that rounds up to exactly the normal boundary packs as exponent 1 with a zero fraction. Inexact is set and underflow is not.
- R8: If the final biased exponent is 255 or more, overflow and inexact are both raised. The result is infinity in mode 0, in mode 2 for a positive sign and in mode 3 for a negative sign. Otherwise the result is exponent 254 with an all-ones fraction.
- R9: The output sign bit always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input result present this cycle |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign of the input |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 32 | Mantissa, leading one in bit 31 |
| rnd_mode | input | 2 | Rounding mode (see R4) |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Packed word present |
| out_word | output | 32 | Packed single word |
| flag_of | output | 1 | Overflow |
| flag_uf | output | 1 | Underflow |
| flag_nx | output | 1 | Inexact |

## Verification
Rounding and exponent adjustment can act on the same operand: a carry out of the fraction can push a normal value from biased exponent 254 into overflow, or push a subnormal value into the smallest normal. The sweep sets up both cases with all-ones fractions that have guard bits set, at biased exponents 0, 254 and their neighbours, in every mode and for both signs. Each packed word and flag set is compared with a value that the bench computes bit by bit by shifting the mantissa.

// File: rtl/sp_packer.sv
module sp_packer #(
  parameter int MANT_W   = 32,
  parameter int FRAC_W   = 23,
  parameter int EXP_W    = 8,
  parameter int IN_EXP_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_class,
  input  logic                       in_sign,
  input  logic signed [IN_EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]          in_mant,
  input  logic [1:0]                 rnd_mode,
  input  logic                       uf_trap_en,
  output logic                       out_valid,
  output logic [EXP_W+FRAC_W:0]      out_word,
  output logic                       flag_of,
  output logic                       flag_uf,
  output logic                       flag_nx
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int GSH   = MANT_W - FRAC_W - 1;
  localparam int VW    = FRAC_W + 3;
  localparam int EX_W  = $clog2(VW + 1);
  localparam int BE_W  = IN_EXP_W + 2;
  localparam int DW    = BE_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX  = (1 << EXP_W) - 1;

  localparam logic [1:0] C_ZERO = 2'b00;
  localparam logic [1:0] C_NUM  = 2'b01;
  localparam logic [1:0] C_INF  = 2'b10;

  localparam logic [1:0] M_NEAR = 2'd0;
  localparam logic [1:0] M_ZERO = 2'd1;
  localparam logic [1:0] M_POS  = 2'd2;

  logic signed [BE_W-1:0] biased, e_fin;
  logic signed [DW-1:0]   deficit;
  logic                   is_sub;
  logic [EX_W-1:0]        extra;
  logic [VW-1:0]          v;
  logic [2*VW-1:0]        w;
  logic [FRAC_W:0]        kept;
  logic                   rbit, stk, inexact, up, to_inf, ovf;
  logic [FRAC_W+1:0]      sum;

  logic [W-1:0] res_word;
  logic         res_of, res_uf, res_nx;

  assign biased  = BE_W'(in_exp) + BE_W'(BIAS);
  assign is_sub  = biased[BE_W-1] | (biased == '0);
  assign deficit = DW'(1) - DW'(biased);

  always_comb begin
    if (!is_sub)
      extra = '0;
    else if (deficit > DW'(VW))
      extra = EX_W'(VW);
    else
      extra = deficit[EX_W-1:0];
  end

  assign v = {in_mant[MANT_W-1:GSH], in_mant[GSH-1], |in_mant[GSH-2:0]};
  assign w = {v, {VW{1'b0}}} >> extra;
  assign kept    = w[2*VW-1:VW+2];
  assign rbit    = w[VW+1];
  assign stk     = |w[VW:0];
  assign inexact = rbit | stk;

  always_comb begin
    case (rnd_mode)
      M_NEAR:  up = rbit & (stk | kept[0]);
      M_ZERO:  up = 1'b0;
      M_POS:   up = inexact & ~in_sign;
      default: up = inexact & in_sign;
    endcase
  end

  always_comb begin
    case (rnd_mode)
      M_NEAR:  to_inf = 1'b1;
      M_ZERO:  to_inf = 1'b0;
      M_POS:   to_inf = ~in_sign;
      default: to_inf = in_sign;
    endcase
  end

  assign sum   = {1'b0, kept} + {{(FRAC_W+1){1'b0}}, up};
  assign e_fin = biased + BE_W'(sum[FRAC_W+1]);
  assign ovf   = !is_sub && (e_fin >= BE_W'(EMAX));

  always_comb begin
    res_word = {in_sign, {(W-1){1'b0}}};
    res_of   = 1'b0;
    res_uf   = 1'b0;
    res_nx   = 1'b0;
    case (in_class)
      C_ZERO: ;
      C_INF:  res_word = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      C_NUM: begin
        res_nx = inexact;
        if (is_sub) begin
          if (sum[FRAC_W]) begin
            res_word = {in_sign, EXP_W'(1), {FRAC_W{1'b0}}};
          end else begin
            res_word = {in_sign, {EXP_W{1'b0}}, sum[FRAC_W-1:0]};
            res_uf   = inexact | uf_trap_en;
          end
        end else if (ovf) begin
          res_of = 1'b1;
          res_nx = 1'b1;
          if (to_inf)
            res_word = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          else
            res_word = {in_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
          res_word = {in_sign, e_fin[EXP_W-1:0], sum[FRAC_W-1:0]};
        end
      end
      default: res_word = {in_sign, {EXP_W{1'b1}}, in_mant[MANT_W-2 -: FRAC_W]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      flag_of   <= 1'b0;
      flag_uf   <= 1'b0;
      flag_nx   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= res_word;
        flag_of  <= res_of;
        flag_uf  <= res_uf;
        flag_nx  <= res_nx;
      end
    end
  end
endmodule

// File: rtl/sp_packer_chk.sv
module sp_packer_chk #(
  parameter int FRAC_W = 23,
  parameter int EXP_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [1:0]            in_class,
  input logic                  in_sign,
  input logic [1:0]            rnd_mode,
  input logic                  uf_trap_en,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_word,
  input logic                  flag_of,
  input logic                  flag_uf,
  input logic                  flag_nx
);
  localparam int W = EXP_W + FRAC_W + 1;
  logic [EXP_W-1:0] oexp;
  assign oexp = out_word[W-2:FRAC_W];

  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid && $stable(out_word) && $stable(flag_nx)); // R3
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_word[W-1] == $past(in_sign)); // R9
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_class == 2'b00 |=> out_word[W-2:0] == '0 && !flag_of && !flag_uf && !flag_nx); // R1
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_class == 2'b11 |=> oexp == '1 && !flag_of && !flag_uf && !flag_nx); // R2
  AST_OVF_WITH_NX: assert property (@(posedge clk) disable iff (!rst_n) out_valid && flag_of |-> flag_nx && !flag_uf); // R8
  AST_RZ_FINITE: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_class == 2'b01 && rnd_mode == 2'd1 |=> oexp != '1); // R8
  AST_UF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_class == 2'b01 && !uf_trap_en |=> !flag_uf || flag_nx); // R6
  AST_UF_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid && flag_uf |-> oexp == '0); // R6
endmodule

bind sp_packer sp_packer_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .in_sign(in_sign), .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en),
  .out_valid(out_valid), .out_word(out_word), .flag_of(flag_of),
  .flag_uf(flag_uf), .flag_nx(flag_nx)
);

// File: tb/sp_packer_test.sv
module sp_packer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_class = 2'b00;
  logic in_sign = 1'b0;
  logic signed [15:0] in_exp = '0;
  logic [31:0] in_mant = '0;
  logic [1:0] rnd_mode = 2'd0;
  logic uf_trap_en = 1'b0;
  logic out_valid;
  logic [31:0] out_word;
  logic flag_of, flag_uf, flag_nx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sp_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .rnd_mode(rnd_mode),
    .uf_trap_en(uf_trap_en), .out_valid(out_valid), .out_word(out_word),
    .flag_of(flag_of), .flag_uf(flag_uf), .flag_nx(flag_nx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ref_pack(input logic [1:0] cls, input logic sgn, input int bexp,
                          input logic [31:0] m, input logic [1:0] md, input logic trap,
                          output logic [31:0] wd, output logic [2:0] fl, output string tag);
    longint q;
    int s, e;
    bit rb, st, nx, up, inf;
    wd = {sgn, 31'd0};
    fl = 3'b000;
    case (cls)
      2'b00: tag = "R1 zero";
      2'b10: begin wd = {sgn, 8'hFF, 23'd0}; tag = "R1 infinity"; end
      2'b11: begin wd = {sgn, 8'hFF, m[30:8]}; tag = "R2 nan"; end
      default: begin
        q = longint'(m);
        s = (bexp <= 0) ? 9 - bexp : 8;
        if (s > 40) s = 40;
        rb = 0; st = 0;
        for (int i = 0; i < s; i++) begin
          st = st | rb;
          rb = q[0];
          q = q >> 1;
        end
        nx = rb | st;
        case (md)
          2'd0: up = rb & (st | q[0]);
          2'd1: up = 0;
          2'd2: up = nx & !sgn;
          default: up = nx & sgn;
        endcase
        q = q + longint'(up);
        if (bexp <= 0) begin
          if (q == (64'd1 << 23)) begin
            wd = {sgn, 8'd1, 23'd0}; fl = {2'b00, nx}; tag = "R7 subnormal to normal";
          end else begin
            wd = {sgn, 8'd0, q[22:0]}; fl = {1'b0, nx | trap, nx}; tag = "R6 subnormal";
          end
        end else begin
          e = bexp + int'(q >> 24);
          tag = (q >> 24) != 0 ? "R5 carry" : "R4 normal";
          if (e >= 255) begin
            inf = (md == 2'd0) || (md == 2'd2 && !sgn) || (md == 2'd3 && sgn);
            wd = inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
            fl = 3'b101; tag = "R8 overflow";
          end else begin
            wd = {sgn, 8'(e), q[22:0]}; fl = {2'b00, nx};
          end
        end
      end
    endcase
  endtask

  task automatic run_one(input logic [1:0] cls, input logic sgn, input int bexp,
                         input logic [31:0] m, input logic [1:0] md, input logic trap);
    logic [31:0] wd;
    logic [2:0] fl;
    string tag;
    ref_pack(cls, sgn, bexp, m, md, trap, wd, fl, tag);
    in_valid = 1; in_class = cls; in_sign = sgn; in_exp = 16'(bexp - 127);
    in_mant = m; rnd_mode = md; uf_trap_en = trap;
    @(negedge clk);
    chk({tag, " word"}, out_word, wd);
    chk({tag, " flags"}, {29'd0, flag_of, flag_uf, flag_nx}, {29'd0, fl});
    chk("R9 sign", {31'd0, out_word[31]}, {31'd0, sgn});
    chk("R3 valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    int bexps[16] = '{-40, -24, -23, -22, -1, 0, 1, 2, 127, 253, 254, 255, 256, 300, 32894, -32641};
    logic [31:0] mants[12] = '{32'h80000000, 32'hFFFFFFFF, 32'hFFFFFF80, 32'hFFFFFF7F,
                               32'h80000080, 32'h80000180, 32'h800000C0, 32'h80000001,
                               32'hFFFFFE80, 32'hC0000000, 32'hAAAAAAAA, 32'h80000100};
    logic [31:0] lf = 32'h1234_5678;
    logic [31:0] last_w;
    logic [2:0] last_f;
    repeat (3) @(negedge clk);
    chk("R3 reset word", out_word, 32'd0);
    chk("R3 reset flags/valid", {28'd0, out_valid, flag_of, flag_uf, flag_nx}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int b = 0; b < 16; b++)
      for (int k = 0; k < 14; k++) begin
        logic [31:0] m;
        if (k < 12) m = mants[k];
        else begin
          lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
          m = lf | 32'h80000000;
        end
        for (int md = 0; md < 4; md++)
          for (int sg = 0; sg < 2; sg++)
            for (int tr = 0; tr < 2; tr++)
              run_one(2'b01, sg[0], bexps[b], m, md[1:0], tr[0]);
      end
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 12; k++)
        for (int sg = 0; sg < 2; sg++)
          run_one(c == 0 ? 2'b00 : (c == 1 ? 2'b10 : 2'b11), sg[0], bexps[k], mants[k] ^ 32'h4000_0155, 2'(k), k[0]);
    run_one(2'b01, 1'b0, 0, 32'hFFFFFFFF, 2'd2, 1'b0);
    last_w = out_word;
    last_f = {flag_of, flag_uf, flag_nx};
    in_valid = 0; in_class = 2'b01; in_exp = 16'sd200; in_mant = 32'h9000_0001;
    @(negedge clk);
    chk("R3 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R3 idle word hold", out_word, last_w);
    chk("R3 idle flag hold", {29'd0, flag_of, flag_uf, flag_nx}, {29'd0, last_f});
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule